// File: doc/BRIEF.md
# Watchdog Timer with APB Register Port

The block counts a 32-bit value down once per clock and expects software, or any other bus master, to keep it from reaching zero. A refresh is a write of a fixed 32-bit key to the refresh register, and it reloads the counter from a programmable preset. If the count runs out, the block takes one timeout action. In reset mode it gives a one-cycle reset request. In interrupt mode it sets a sticky timeout interrupt. If the processor is asleep and wake-up is enabled, it sets a wake-up interrupt in place of either action. While the debug-halt input is high, the count is held.

A three-state machine drives the counter. COUNT decrements the counter. FROZEN holds the counter. EXPIRE lasts one cycle, takes the action and reloads the counter. The transitions are as follows:
- COUNT to FROZEN when debug-halt is high.
- COUNT to EXPIRE when the count is zero, no refresh is written in that cycle and debug-halt is low.
- COUNT stays in COUNT on a refresh, which reloads the counter.
- FROZEN back to COUNT when debug-halt falls.
- EXPIRE to FROZEN if debug-halt is high, and to COUNT otherwise.

From reset, one full timeout interval is preset + 2 clock cycles.

The block comes out of reset already counting, in reset mode, with the preset at all ones. Software gets exactly one write to the control register to choose the mode and the wake-up enable. After that write, the control register is locked until the next reset.

Top module: `apb_watchdog`

## Requirements
- R1: After reset:
  - control (offset 0x00) reads 0x1;
  - preset (0x04) reads 0xFFFFFFFF;
  - interrupt status (0x10) reads 0;
  - the reset request and both interrupt outputs are low.
- R2: Every APB transfer completes in its access cycle with PREADY high and PSLVERR low. Reads of the refresh register (0x08), of unused word offsets and of any address with PADDR[1:0] not zero return 0.
- R3: Writing 0x5EEDC0DE to offset 0x08 reloads the counter with the preset (0x04, read/write). The current count (0x0C) read in the access cycle right after the refresh shows preset - 1.
- R4: A write of any other value to offset 0x08 leaves the count undisturbed.
- R5: Outside debug halt, the count drops by exactly one per clock cycle.
- R6: In reset mode (control bit 1 = 0), the cycle after the count sits at zero without a refresh raises reset_req_o for exactly one cycle, preset + 1 cycles after the refresh edge. The counter is then reloaded.
- R7: In interrupt mode (control bit 1 = 1), a timeout sets status bit 0 and irq_timeout_o, preset + 2 cycles after the refresh. The interrupt stays high, the counter reloads from the preset, and no reset request is made.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it. When an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R9: While dbg_halt_i is high, the count holds its value and no timeout happens. Counting resumes when it falls.
- R10: When sleep_i is high and wake enable (control bit 2) is set, a timeout sets status bit 1 and irq_wake_o instead of the reset request or the timeout interrupt.
- R11: The first write to control after reset sets the mode (bit 1) and wake enable (bit 2). Later writes are ignored, and enable (bit 0) always reads 1.
- R12: A refresh accepted in the cycle where the count is zero prevents that timeout. A refresh one cycle later does not.
- R13: The raw status register (0x14) reads:
  - bit 0 = dbg_halt_i;
  - bit 1 = sleep_i;
  - bit 2 = counter frozen (FROZEN state).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Transfer done, always high |
| pslverr | output | 1 | Error response, always low |
| dbg_halt_i | input | 1 | Processor in debug, freezes the count |
| sleep_i | input | 1 | Processor asleep |
| reset_req_o | output | 1 | One-cycle system reset request |
| irq_timeout_o | output | 1 | Sticky timeout interrupt |
| irq_wake_o | output | 1 | Sticky wake-up interrupt |

## Verification
Two pairs of functions can land in the same cycle, and the bench provokes each of them.

The first pair is a refresh and the expiry. The bench times a key write so that its access edge lands exactly on the cycle where the count reads zero. It then expects no reset pulse at that point, and exactly one pulse a full interval later. A second key write lands one cycle later and must not stop that timeout.

The second pair is an event setting a status bit while software clears it. A status write of 1 is placed on the same edge where the EXPIRE cycle sets the timeout bit, and the interrupt must stay high afterwards.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_COUNT  = 2'd0,
        WD_FROZEN = 2'd1,
        WD_EXPIRE = 2'd2
    } wd_state_e;

    // word index of each register (byte offset / 4)
    localparam int unsigned RI_CTRL   = 0;
    localparam int unsigned RI_PRESET = 1;
    localparam int unsigned RI_KICK   = 2;
    localparam int unsigned RI_COUNT  = 3;
    localparam int unsigned RI_ISTAT  = 4;
    localparam int unsigned RI_RAW    = 5;

    // control field positions
    localparam int unsigned CTRL_MODE_BIT = 1;
    localparam int unsigned CTRL_WAKE_BIT = 2;

    // status event positions
    localparam int unsigned EV_TMO  = 0;
    localparam int unsigned EV_WAKE = 1;
    localparam int unsigned EV_N    = 2;

endpackage

// File: rtl/wdog_cnt_fsm.sv
module wdog_cnt_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] preset_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             frozen_o,
    output logic             expire_o
);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_COUNT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_COUNT: begin
                if (halt_i)                 state_d = WD_FROZEN;
                else if (!kick_i && at_zero) state_d = WD_EXPIRE;
                else                        state_d = WD_COUNT;
            end
            WD_FROZEN: state_d = halt_i ? WD_FROZEN : WD_COUNT;
            WD_EXPIRE: state_d = halt_i ? WD_FROZEN : WD_COUNT;
            default:   state_d = WD_COUNT;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        frozen_o = 1'b0;
        expire_o = 1'b0;
        unique case (state_q)
            WD_FROZEN: frozen_o = 1'b1;
            WD_EXPIRE: expire_o = 1'b1;
            default: ;
        endcase
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (kick_i || state_q == WD_EXPIRE) begin
            cnt_q <= preset_i;
        end else if (state_q == WD_COUNT && !halt_i && !at_zero) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wdog_action.sv
module wdog_action (
    input  logic expire_i,
    input  logic sleep_i,
    input  logic wake_en_i,
    input  logic mode_irq_i,
    output logic reset_req_o,
    output logic set_tmo_o,
    output logic set_wake_o
);

    logic wake_hit;

    always_comb begin
        wake_hit    = expire_i && sleep_i && wake_en_i;
        set_wake_o  = wake_hit;
        reset_req_o = expire_i && !wake_hit && !mode_irq_i;
        set_tmo_o   = expire_i && !wake_hit && mode_irq_i;
    end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int              DATA_W = 32,
    parameter int              ADDR_W = 5,
    parameter logic [DATA_W-1:0] KEY  = 32'h5EED_C0DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic              frozen_i,
    input  logic              halt_i,
    input  logic              sleep_i,
    input  logic              set_tmo_i,
    input  logic              set_wake_i,
    output logic              kick_o,
    output logic [DATA_W-1:0] preset_o,
    output logic              mode_irq_o,
    output logic              wake_en_o,
    output logic              lock_o,
    output logic              irq_tmo_o,
    output logic              irq_wake_o
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] A_CTRL   = IDX_W'(RI_CTRL);
    localparam logic [IDX_W-1:0] A_PRESET = IDX_W'(RI_PRESET);
    localparam logic [IDX_W-1:0] A_KICK   = IDX_W'(RI_KICK);
    localparam logic [IDX_W-1:0] A_COUNT  = IDX_W'(RI_COUNT);
    localparam logic [IDX_W-1:0] A_ISTAT  = IDX_W'(RI_ISTAT);
    localparam logic [IDX_W-1:0] A_RAW    = IDX_W'(RI_RAW);

    logic             hit, wr_en;
    logic [IDX_W-1:0] idx;
    logic             mode_q, wake_q, lock_q;
    logic [DATA_W-1:0] preset_q;
    logic [EV_N-1:0]  istat_q, ev_set;

    assign idx   = paddr[ADDR_W-1:2];
    assign hit   = psel && (paddr[1:0] == 2'b00);
    assign wr_en = hit && penable && pwrite;

    // control: one configuration write, then locked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            wake_q <= 1'b0;
            lock_q <= 1'b0;
        end else if (wr_en && idx == A_CTRL && !lock_q) begin
            mode_q <= pwdata[CTRL_MODE_BIT];
            wake_q <= pwdata[CTRL_WAKE_BIT];
            lock_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         preset_q <= '1;
        else if (wr_en && idx == A_PRESET)  preset_q <= pwdata;
    end

    assign kick_o = wr_en && (idx == A_KICK) && (pwdata == KEY);

    // sticky status bits, set beats clear
    always_comb begin
        ev_set          = '0;
        ev_set[EV_TMO]  = set_tmo_i;
        ev_set[EV_WAKE] = set_wake_i;
    end

    for (genvar g = 0; g < EV_N; g++) begin : g_istat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   istat_q[g] <= 1'b0;
            else if (ev_set[g])                           istat_q[g] <= 1'b1;
            else if (wr_en && idx == A_ISTAT && pwdata[g]) istat_q[g] <= 1'b0;
        end
    end

    // read path, zero wait states
    always_comb begin
        prdata = '0;
        if (hit && !pwrite) begin
            case (idx)
                A_CTRL:   prdata = {{(DATA_W-3){1'b0}}, wake_q, mode_q, 1'b1};
                A_PRESET: prdata = preset_q;
                A_KICK:   prdata = '0;
                A_COUNT:  prdata = cnt_i;
                A_ISTAT:  prdata = {{(DATA_W-EV_N){1'b0}}, istat_q};
                A_RAW:    prdata = {{(DATA_W-3){1'b0}}, frozen_i, sleep_i, halt_i};
                default:  prdata = '0;
            endcase
        end
    end

    assign preset_o   = preset_q;
    assign mode_irq_o = mode_q;
    assign wake_en_o  = wake_q;
    assign lock_o     = lock_q;
    assign irq_tmo_o  = istat_q[EV_TMO];
    assign irq_wake_o = istat_q[EV_WAKE];

endmodule

// File: rtl/apb_watchdog.sv
module apb_watchdog #(
    parameter int                DATA_W = 32,
    parameter int                ADDR_W = 5,
    parameter logic [DATA_W-1:0] KEY    = 32'h5EED_C0DE
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              dbg_halt_i,
    input  logic              sleep_i,
    output logic              reset_req_o,
    output logic              irq_timeout_o,
    output logic              irq_wake_o
);

    logic [DATA_W-1:0] cur_cnt, cur_preset;
    logic              kick, frozen, expire;
    logic              cfg_mode, cfg_wake, cfg_lock;
    logic              set_tmo, set_wake;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    wdog_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .KEY    (KEY)
    ) u_regs (
        .clk        (pclk),
        .rst_n      (presetn),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .prdata     (prdata),
        .cnt_i      (cur_cnt),
        .frozen_i   (frozen),
        .halt_i     (dbg_halt_i),
        .sleep_i    (sleep_i),
        .set_tmo_i  (set_tmo),
        .set_wake_i (set_wake),
        .kick_o     (kick),
        .preset_o   (cur_preset),
        .mode_irq_o (cfg_mode),
        .wake_en_o  (cfg_wake),
        .lock_o     (cfg_lock),
        .irq_tmo_o  (irq_timeout_o),
        .irq_wake_o (irq_wake_o)
    );

    wdog_cnt_fsm #(
        .CNT_W (DATA_W)
    ) u_fsm (
        .clk      (pclk),
        .rst_n    (presetn),
        .halt_i   (dbg_halt_i),
        .kick_i   (kick),
        .preset_i (cur_preset),
        .cnt_o    (cur_cnt),
        .frozen_o (frozen),
        .expire_o (expire)
    );

    wdog_action u_action (
        .expire_i    (expire),
        .sleep_i     (sleep_i),
        .wake_en_i   (cfg_wake),
        .mode_irq_i  (cfg_mode),
        .reset_req_o (reset_req_o),
        .set_tmo_o   (set_tmo),
        .set_wake_o  (set_wake)
    );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              wdata_b0,
    input logic              halt,
    input logic              rst_req,
    input logic              irq_tmo,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] preset,
    input logic              kick,
    input logic              frozen,
    input logic              lock,
    input logic              mode
);

    logic clr_tmo;
    assign clr_tmo = psel && penable && pwrite && (paddr == ADDR_W'(16)) && wdata_b0;

    a_r6_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r6_rst_only_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !mode);

    a_r9_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && frozen && !kick) |=> $stable(cnt));

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tmo && !clr_tmo) |=> irq_tmo);

    a_r3_kick_reload: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == $past(preset)));

    a_r11_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> (lock && $stable(mode)));

endmodule

bind apb_watchdog wdog_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) i_wdog_checker (
    .clk      (pclk),
    .rst_n    (presetn),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .wdata_b0 (pwdata[0]),
    .halt     (dbg_halt_i),
    .rst_req  (reset_req_o),
    .irq_tmo  (irq_timeout_o),
    .cnt      (cur_cnt),
    .preset   (cur_preset),
    .kick     (kick),
    .frozen   (frozen),
    .lock     (cfg_lock),
    .mode     (cfg_mode)
);

// File: tb/test_apb_watchdog.sv
module test_apb_watchdog;

    localparam logic [31:0] KEY = 32'h5EED_C0DE;
    localparam logic [4:0] O_CTRL = 5'h00, O_PRE = 5'h04, O_KICK = 5'h08,
                           O_CNT = 5'h0C, O_IST = 5'h10, O_RAW = 5'h14;

    logic        clk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        halt = 1'b0, sleep = 1'b0;
    logic        rst_req, irq_tmo, irq_wake;

    int checks = 0;
    int errors = 0;
    int rst_cnt = 0;
    int rc;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    apb_watchdog i_apb_watchdog (
        .pclk          (clk),
        .presetn       (presetn),
        .psel          (psel),
        .penable       (penable),
        .pwrite        (pwrite),
        .paddr         (paddr),
        .pwdata        (pwdata),
        .prdata        (prdata),
        .pready        (pready),
        .pslverr       (pslverr),
        .dbg_halt_i    (halt),
        .sleep_i       (sleep),
        .reset_req_o   (rst_req),
        .irq_timeout_o (irq_tmo),
        .irq_wake_o    (irq_wake)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard for reads, reset pulse counter
    always @(negedge clk) begin : mon
        logic [31:0] e;
        string       t;
        #1;
        if (presetn && psel && penable && !pwrite) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected read", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, prdata, e);
                chk("R2 ready/no error", {30'd0, pready, pslverr}, 32'd2);
            end
        end
        if (presetn && rst_req) rst_cnt++;
    end

    task automatic apb_wr(logic [4:0] a, logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge clk);
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(logic [4:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(posedge clk);
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // sel: 0 reset request, 1 timeout irq, 2 wake irq; hit 0 = never
    task automatic watch(int n, int hit, int sel, bit level, string tag);
        for (int i = 1; i <= n; i++) begin
            logic v, ev;
            @(negedge clk);
            #1;
            v  = (sel == 0) ? rst_req : (sel == 1) ? irq_tmo : irq_wake;
            ev = (hit == 0) ? 1'b0 : (level ? (i >= hit) : (i == hit));
            chk(tag, {31'd0, v}, {31'd0, ev});
        end
    endtask

    task automatic do_reset();
        presetn = 1'b0;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        halt = 1'b0; sleep = 1'b0;
        idle(3);
        presetn = 1'b1;
        idle(1);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // ---------------- phase 1: reset mode, P = 40 ----------------
        do_reset();
        chk("R1 reset_req low", {31'd0, rst_req}, 32'd0);
        chk("R1 irq outputs low", {30'd0, irq_tmo, irq_wake}, 32'd0);
        apb_rd(O_CTRL, 32'h1, "R1 ctrl reset value");
        apb_rd(O_PRE, 32'hFFFF_FFFF, "R1 preset reset value");
        apb_rd(O_IST, 32'h0, "R1 status reset value");

        apb_wr(O_CTRL, 32'h5);
        apb_rd(O_CTRL, 32'h5, "R11 first config write");
        apb_wr(O_CTRL, 32'h2);
        apb_rd(O_CTRL, 32'h5, "R11 later write ignored");

        apb_wr(O_PRE, 32'd40);
        apb_rd(O_PRE, 32'd40, "R3 preset readback");
        apb_rd(O_KICK, 32'h0, "R2 refresh reg reads zero");
        apb_rd(5'h1C, 32'h0, "R2 unused offset reads zero");
        apb_rd(5'h0D, 32'h0, "R2 misaligned reads zero");

        apb_wr(O_KICK, KEY);
        apb_rd(O_CNT, 32'd39, "R3 reload on key");
        apb_rd(O_CNT, 32'd37, "R5 one per cycle");

        apb_wr(O_KICK, KEY);
        apb_wr(O_KICK, KEY ^ 32'h1);
        apb_rd(O_CNT, 32'd37, "R4 wrong key ignored");
        apb_rd(O_RAW, 32'h0, "R13 raw idle");

        // R6 pulse position and width
        apb_wr(O_KICK, KEY);
        watch(42, 41, 0, 1'b0, "R6 reset pulse");

        // R12 refresh exactly at zero count
        rc = rst_cnt;
        apb_wr(O_KICK, KEY);
        watch(39, 0, 0, 1'b0, "R12 no early pulse");
        apb_wr(O_KICK, KEY);
        watch(42, 41, 0, 1'b0, "R12 refresh at zero restarts interval");
        idle(2);
        chk("R12 single pulse after zero-count refresh", rst_cnt, rc + 1);

        // R12 refresh one cycle late
        rc = rst_cnt;
        apb_wr(O_KICK, KEY);
        watch(40, 0, 0, 1'b0, "R12 quiet before late refresh");
        apb_wr(O_KICK, KEY);
        idle(2);
        chk("R12 late refresh does not stop timeout", rst_cnt, rc + 1);

        // R9 debug halt
        apb_wr(O_KICK, KEY);
        halt = 1'b1;
        rc = rst_cnt;
        idle(60);
        apb_rd(O_CNT, 32'd40, "R9 count held");
        apb_rd(O_RAW, 32'h5, "R13 raw halt and frozen");
        idle(2);
        chk("R9 no timeout while halted", rst_cnt, rc);
        halt = 1'b0;
        idle(50);
        chk("R9 counting resumes", rst_cnt, rc + 1);

        // R10 wake-up replaces reset request
        sleep = 1'b1;
        rc = rst_cnt;
        apb_wr(O_KICK, KEY);
        watch(42, 42, 2, 1'b1, "R10 wake irq");
        chk("R10 no timeout irq", {31'd0, irq_tmo}, 32'd0);
        idle(2);
        chk("R10 no reset request", rst_cnt, rc);
        apb_rd(O_IST, 32'h2, "R10 wake status bit");
        apb_wr(O_IST, 32'h2);
        apb_rd(O_IST, 32'h0, "R8 wake bit cleared");
        sleep = 1'b0;

        // ---------------- phase 2: interrupt mode, P = 30 ----------------
        do_reset();
        apb_wr(O_CTRL, 32'h3);
        apb_rd(O_CTRL, 32'h3, "R11 interrupt mode set");
        apb_wr(O_CTRL, 32'h0);
        apb_rd(O_CTRL, 32'h3, "R11 enable and mode locked");
        apb_wr(O_PRE, 32'd30);

        rc = rst_cnt;
        apb_wr(O_KICK, KEY);
        watch(32, 32, 1, 1'b1, "R7 timeout irq");
        apb_rd(O_CNT, 32'd29, "R7 reload after timeout");
        idle(10);
        chk("R7 irq sticky", {31'd0, irq_tmo}, 32'd1);
        chk("R7 no reset request", rst_cnt, rc);

        apb_wr(O_KICK, KEY);
        apb_rd(O_IST, 32'h1, "R7 status bit");
        apb_wr(O_IST, 32'h2);
        chk("R8 write 0 leaves bit", {31'd0, irq_tmo}, 32'd1);
        apb_wr(O_IST, 32'h1);
        chk("R8 write 1 clears", {31'd0, irq_tmo}, 32'd0);

        // R8 set and clear on the same edge
        apb_wr(O_KICK, KEY);
        apb_wr(O_IST, 32'h1);
        apb_rd(O_IST, 32'h0, "R8 clear before race");
        idle(26);
        apb_wr(O_IST, 32'h1);
        chk("R8 set wins over clear", {31'd0, irq_tmo}, 32'd1);
        apb_rd(O_IST, 32'h1, "R8 status after race");

        sleep = 1'b1;
        idle(1);
        apb_rd(O_RAW, 32'h2, "R13 raw sleep");
        sleep = 1'b0;
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule